// File: doc/BRIEF.md
# Sleep and Hard-Reset Mode Controller

This block sits beside the digital core of a motor driver and governs two of its global modes. A sleep control bit, taken from the register file, moves the core into a low-power state. In that state the output stage is floated, the analog circuits are switched off and the core clock enable drops. The clock enable comes back only while a serial access is in progress, so that registers stay reachable. Leaving sleep brings the clock and the analog circuits back first. The output stage is released one cycle later.

An active-high clear input, which may arrive from outside the clock domain, is synchronised and filtered. Once it has been seen high for a parameterised number of consecutive cycles, the block issues a single-cycle register-clear pulse to the core. While the block is asleep or waking, the clear input has no effect. The step and direction inputs are gated in the same way. The block also folds the fault flags of the driver into one active-low error output.

Top module: `sleep_reset_ctrl`

## Requirements
- R1: `err_n` is 0 in the same cycle that any of `therm_warn`, `therm_shut`, `pump_fail`, any bit of `ovc_flags` or any bit of `open_flags` is 1, and it is 1 otherwise.
- R2: When `clr_in` is sampled high at CLR_CYC consecutive rising edges while the block is running, `reg_clear` goes high for exactly one cycle, starting two edges after the last of those samples. Only one pulse is given per high period of `clr_in`.
- R3: A high period of `clr_in` shorter than CLR_CYC sampled edges produces no `reg_clear` pulse.
- R4: When `sleep_req` is sampled 1 at a rising edge while the block is running, `drv_hiz` and `ana_off` are both 1 from that edge on.
- R5: When `sleep_req` is sampled 0 while the block is asleep, `ana_off` falls at that edge and `drv_hiz` falls at the following edge, unless `sleep_req` is 1 again at that edge.
- R6: While `drv_hiz` is 1, `step_out` is 0 and `dir_out` holds the last `dir_in` value seen while running. While running, both outputs follow their inputs in the same cycle.
- R7: `core_clk_en` is 0 only while `ana_off` is 1 and `ser_active` is 0. It rises in the same cycle that `ser_active` rises.
- R8: While `drv_hiz` is 1, `clr_in` is ignored and no `reg_clear` pulse is produced. A clear that is still high after wake-up must meet the full CLR_CYC count again.
- R9: After a synchronous reset (`rst_n` low at an edge), `drv_hiz`, `ana_off`, `reg_clear` and `dir_out` are 0 and `core_clk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Sleep control bit from the register file |
| clr_in | input | 1 | Active-high hard-clear request, asynchronous |
| step_in | input | 1 | Step input |
| dir_in | input | 1 | Direction input |
| ser_active | input | 1 | A serial access is in progress |
| therm_warn | input | 1 | Thermal warning flag |
| therm_shut | input | 1 | Thermal shutdown flag |
| ovc_flags | input | NOVC | Overcurrent flags, one per output transistor |
| open_flags | input | NOPEN | Open-coil flags, one per coil |
| pump_fail | input | 1 | Charge-pump failure flag |
| drv_hiz | output | 1 | Output stage high-impedance enable |
| ana_off | output | 1 | Analog circuits disable |
| core_clk_en | output | 1 | Core clock enable |
| reg_clear | output | 1 | Single-cycle register clear pulse |
| step_out | output | 1 | Gated step to the core |
| dir_out | output | 1 | Gated direction to the core |
| err_n | output | 1 | Active-low combined fault flag |

## Verification
The bench goes after a clear held for exactly CLR_CYC-1 and exactly CLR_CYC edges. A filter that counts one edge short or one edge long would fire on the short hold or stay silent on the exact one. It holds the clear through a whole sleep period and across wake-up, where a design that does not gate or does not restart its count would pulse early. It drops the sleep bit and checks that the output stage is released one cycle after the analog circuits, which catches a wake-up sequence that releases both together. It also toggles serial access and direction during sleep. This catches a clock enable that stays off during an access, and a direction output that leaks through while the block is asleep.

// File: rtl/srm_pkg.sv
// Package: shared types for the sleep / hard-reset controller.
package srm_pkg;
    // Operating mode of the controller.
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_WAKE  = 2'd2
    } mode_e;
endpackage

// File: rtl/srm_fault_merge.sv
// Folds the driver fault flags into one active-low error output.
// Assumes the flags are already synchronous to the core clock.
module srm_fault_merge #(
    parameter int NOVC  = 8,
    parameter int NOPEN = 2
) (
    input  logic             therm_warn,
    input  logic             therm_shut,
    input  logic [NOVC-1:0]  ovc_flags,
    input  logic [NOPEN-1:0] open_flags,
    input  logic             pump_fail,
    output logic             err_n
);
    logic any_fault;

    // Any single flag pulls the error output low.
    always_comb begin
        any_fault = therm_warn | therm_shut | pump_fail | (|ovc_flags) | (|open_flags);
        err_n     = ~any_fault;
    end
endmodule

// File: rtl/srm_clr_filter.sv
// Synchronises the asynchronous clear input with two flops and accepts it only
// after CLR_CYC consecutive high samples. It gives one pulse per high period.
// While block_i is high the count is held at zero, so a clear is ignored.
module srm_clr_filter #(
    parameter int CLR_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_in,
    input  logic block_i,
    output logic reg_clear_o
);
    localparam int CW = $clog2(CLR_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(CLR_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(CLR_CYC - 1);

    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    // Two-flop synchroniser on the clear input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= clr_in;
            sync2 <= sync1;
        end
    end

    // Count high samples, saturating at the limit, and restart while blocked.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync2 || block_i) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Emit the one-cycle pulse as the count reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_clear_o <= 1'b0;
        end else begin
            reg_clear_o <= sync2 && !block_i && (cnt == CNT_LAST);
        end
    end

    AST_CLR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clear_o |=> !reg_clear_o); // R2
    AST_CLR_NOT_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clear_o |-> !$past(block_i)); // R8
endmodule

// File: rtl/srm_sleep_fsm.sv
// Sleep mode sequencer. RUN enters SLEEP when the sleep bit is seen. SLEEP
// goes through a one-cycle WAKE, in which the clocks and the analog circuits
// are back on but the output stage is still floated, before RUN.
module srm_sleep_fsm
    import srm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic ser_active,
    output logic drv_hiz,
    output logic ana_off,
    output logic core_clk_en,
    output logic running
);
    mode_e mode_q, mode_d;

    // Next-mode decision.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN:   if (sleep_req)  mode_d = MODE_SLEEP;
            MODE_SLEEP: if (!sleep_req) mode_d = MODE_WAKE;
            MODE_WAKE:  mode_d = sleep_req ? MODE_SLEEP : MODE_RUN;
            default:    mode_d = MODE_RUN;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    // Output decode; the clock enable is reopened by a serial access.
    always_comb begin
        running     = (mode_q == MODE_RUN);
        drv_hiz     = !running;
        ana_off     = (mode_q == MODE_SLEEP);
        core_clk_en = !ana_off || ser_active;
    end

    AST_ANA_OFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        ana_off |-> drv_hiz); // R4
    AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ana_off) |-> drv_hiz); // R5
    AST_CLK_OFF_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> (ana_off && !ser_active)); // R7
endmodule

// File: rtl/srm_step_gate.sv
// Blocks the step input and freezes the direction while the core is not running.
module srm_step_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic step_in,
    input  logic dir_in,
    output logic step_out,
    output logic dir_out
);
    logic dir_hold;

    // Remember the last direction seen while running.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_hold <= 1'b0;
        else if (running) dir_hold <= dir_in;
    end

    // Pass-through while running, otherwise blocked or frozen.
    always_comb begin
        step_out = running && step_in;
        dir_out  = running ? dir_in : dir_hold;
    end

    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(!running)) |-> $stable(dir_out)); // R6
endmodule

// File: rtl/sleep_reset_ctrl.sv
// Top: sleep / hard-reset mode controller for a driver's digital core.
// Assumes all inputs except clr_in are synchronous to clk.
module sleep_reset_ctrl #(
    parameter int NOVC    = 8,
    parameter int NOPEN   = 2,
    parameter int CLR_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             clr_in,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic             ser_active,
    input  logic             therm_warn,
    input  logic             therm_shut,
    input  logic [NOVC-1:0]  ovc_flags,
    input  logic [NOPEN-1:0] open_flags,
    input  logic             pump_fail,
    output logic             drv_hiz,
    output logic             ana_off,
    output logic             core_clk_en,
    output logic             reg_clear,
    output logic             step_out,
    output logic             dir_out,
    output logic             err_n
);
    logic running;

    srm_sleep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .ser_active  (ser_active),
        .drv_hiz     (drv_hiz),
        .ana_off     (ana_off),
        .core_clk_en (core_clk_en),
        .running     (running)
    );

    srm_clr_filter #(.CLR_CYC(CLR_CYC)) u_clr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_in      (clr_in),
        .block_i     (!running),
        .reg_clear_o (reg_clear)
    );

    srm_step_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .step_in  (step_in),
        .dir_in   (dir_in),
        .step_out (step_out),
        .dir_out  (dir_out)
    );

    srm_fault_merge #(.NOVC(NOVC), .NOPEN(NOPEN)) u_fault (
        .therm_warn (therm_warn),
        .therm_shut (therm_shut),
        .ovc_flags  (ovc_flags),
        .open_flags (open_flags),
        .pump_fail  (pump_fail),
        .err_n      (err_n)
    );

    AST_STEP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hiz |-> !step_out); // R6
endmodule

// File: tb/tb_sleep_reset_ctrl.sv
module tb_sleep_reset_ctrl;
    localparam int NOVC = 8, NOPEN = 2, CLR_CYC = 6;

    logic clk = 0, rst_n = 0;
    logic sleep_req = 0, clr_in = 0, step_in = 0, dir_in = 0, ser_active = 0;
    logic therm_warn = 0, therm_shut = 0, pump_fail = 0;
    logic [NOVC-1:0]  ovc_flags = '0;
    logic [NOPEN-1:0] open_flags = '0;
    logic drv_hiz, ana_off, core_clk_en, reg_clear, step_out, dir_out, err_n;

    int errors = 0, checks = 0, pulses = 0;

    always #5 clk = ~clk;

    sleep_reset_ctrl #(.NOVC(NOVC), .NOPEN(NOPEN), .CLR_CYC(CLR_CYC)) dut (.*);

    // Reference model: mode 0 run, 1 asleep, 2 waking
    int m_mode = 0, m_run = 0, m_pulse = 0, m_seen = 0;
    logic m_d1 = 0, m_d2 = 0, m_dir = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 0; m_run <= 0; m_pulse <= 0; m_seen <= 0;
            m_d1 <= 0; m_d2 <= 0; m_dir <= 0;
        end else begin
            m_d1 <= clr_in; m_d2 <= m_d1;
            if (m_mode == 0) m_dir <= dir_in;
            // run length of delayed high samples taken while running
            if (m_d2 && m_mode == 0) begin
                m_run   <= m_run + 1;
                m_pulse <= (m_run + 1 == CLR_CYC) ? 1 : 0;
            end else begin
                m_run <= 0; m_pulse <= 0;
            end
            case (m_mode)
                0: m_mode <= sleep_req ? 1 : 0;
                1: m_mode <= sleep_req ? 1 : 2;
                default: m_mode <= sleep_req ? 1 : 0;
            endcase
        end
    end

    function automatic logic exp_err();
        return !(therm_warn | therm_shut | pump_fail | (|ovc_flags) | (|open_flags));
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
        if (reg_clear === 1'b1) pulses++;
        chk("R1", "err_n", err_n, exp_err());
        chk("R2", "reg_clear", reg_clear, m_pulse != 0);
        chk("R4", "drv_hiz", drv_hiz, m_mode != 0);
        chk("R5", "ana_off", ana_off, m_mode == 1);
        chk("R6", "step_out", step_out, (m_mode == 0) && step_in);
        chk("R6", "dir_out", dir_out, (m_mode == 0) ? dir_in : m_dir);
        chk("R7", "core_clk_en", core_clk_en, (m_mode != 1) || ser_active);
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin : watchdog
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5EED_1234));
        wait_n(3);
        rst_n = 1;
        // R9 reset state
        chk("R9", "drv_hiz", drv_hiz, 0);
        chk("R9", "ana_off", ana_off, 0);
        chk("R9", "reg_clear", reg_clear, 0);
        chk("R9", "dir_out", dir_out, 0);
        chk("R9", "core_clk_en", core_clk_en, 1);
        wait_n(2);

        // R3: one sample short gives no pulse
        base = pulses;
        clr_in = 1; wait_n(CLR_CYC - 1); clr_in = 0; wait_n(10);
        chk("R3", "short clear pulse count", (pulses - base) != 0, 0);

        // R2: exact length gives one pulse; long hold still only one
        base = pulses;
        clr_in = 1; wait_n(CLR_CYC); clr_in = 0; wait_n(10);
        chk("R2", "exact clear one pulse", (pulses - base) == 1, 1);
        base = pulses;
        clr_in = 1; wait_n(4 * CLR_CYC); clr_in = 0; wait_n(6);
        chk("R2", "long clear one pulse", (pulses - base) == 1, 1);

        // R4/R8: sleep, clear held throughout, serial access and dir toggles
        dir_in = 1; tick();
        sleep_req = 1; tick();
        chk("R4", "hiz after sleep", drv_hiz, 1);
        base = pulses;
        clr_in = 1; dir_in = 0; step_in = 1;
        wait_n(3 * CLR_CYC);
        ser_active = 1; tick();
        chk("R7", "clk on with access", core_clk_en, 1);
        ser_active = 0; wait_n(2);
        chk("R8", "no pulse asleep", (pulses - base) != 0, 0);
        chk("R6", "dir frozen", dir_out, 1);

        // R5: wake order, clear still high must recount
        sleep_req = 0; tick();
        chk("R5", "ana back on", ana_off, 0);
        chk("R5", "still floated", drv_hiz, 1);
        tick();
        chk("R5", "released", drv_hiz, 0);
        wait_n(CLR_CYC - 2);
        chk("R8", "no early pulse after wake", (pulses - base) != 0, 0);
        wait_n(6);
        chk("R8", "pulse after full recount", (pulses - base) == 1, 1);
        clr_in = 0; step_in = 0; wait_n(4);

        // R1 directed: each fault source alone
        therm_warn = 1; tick(); therm_warn = 0;
        therm_shut = 1; tick(); therm_shut = 0;
        pump_fail = 1; tick(); pump_fail = 0;
        ovc_flags = 8'h80; tick(); ovc_flags = '0;
        open_flags = 2'b01; tick(); open_flags = '0;
        tick();

        // Random phase
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(15) == 0) sleep_req = ~sleep_req;
            if ($urandom_range(9) == 0) clr_in = ~clr_in;
            step_in    = $urandom_range(1);
            dir_in     = $urandom_range(1);
            ser_active = ($urandom_range(3) == 0);
            therm_warn = ($urandom_range(15) == 0);
            therm_shut = ($urandom_range(31) == 0);
            pump_fail  = ($urandom_range(31) == 0);
            ovc_flags  = ($urandom_range(7) == 0) ? NOVC'(1 << $urandom_range(NOVC - 1)) : '0;
            open_flags = ($urandom_range(15) == 0) ? NOPEN'($urandom_range(3)) : '0;
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule